// File: doc/BRIEF.md
# Inbound Address Window Translator

This block sits behind the target side of an external bus. It receives each address presented by an outside initiator and compares it against four programmable windows. Each window holds a 64-bit base, a 32-bit mask-style limit, a 32-bit translate value and a small upper translate value. When a window accepts the address, the block reports a claim and identifies the winning window. It also forms a 36-bit internal address by replacing the masked bits of the incoming address with the window's translate bits.

The block also reports the decode speed a claiming target should use. It signals the fastest decode timing when the bus runs in its extended mode and medium timing in conventional mode. Software or a boot engine programs the windows through a single-cycle write port. A lookup is started with a strobe and answered exactly one clock later.

Top module: `inbound_xlate_top`

## Requirements
- R1: Each of the four windows has its own registers, written when `cfg_we` is high by selecting the window with `cfg_win` and the field with `cfg_sel`: 0 = base low 32 bits, 1 = base high 32 bits, 2 = limit, 3 = translate, 4 = upper translate (taken from `cfg_wdata[3:0]`).
- R2: For a single-address lookup (`in_dac` = 0), a window matches when (`in_addr[31:0]` AND limit) equals base low.
- R3: For a dual-address lookup (`in_dac` = 1), a window also requires `in_addr[63:32]` to equal base high exactly. For single-address lookups, base high and `in_addr[63:32]` are ignored.
- R4: Bits [31:0] of the internal address are (`in_addr[31:0]` AND NOT limit) OR (translate AND limit). Only the low 32 input bits are used, even in dual-address lookups.
- R5: Bits [35:32] of the internal address are the claiming window's upper translate value.
- R6: When several windows match, the lowest-numbered window claims. `out_hit_onehot` has exactly that window's bit set, and `out_hit_idx` gives its number.
- R7: Every lookup strobe `in_valid` produces `out_valid` and the result exactly one clock later. Without a strobe, `out_valid` and `out_claim` are low.
- R8: On a claim, `out_fast_decode` is 1 when `in_ext_mode` was 1 (extended mode, fastest decode) and 0 in conventional mode (medium decode). It is 0 when nothing is claimed.
- R9: Synchronous reset clears every register and output to zero. A window whose base low value is zero never claims.
- R10: An unclaimed result has `out_claim`, `out_hit_onehot`, `out_hit_idx` and `out_iaddr` all zero.
- R11: Writes with a `cfg_sel` value above 4 change no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window selected for write |
| cfg_sel | input | 3 | Field selected for write |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 64 | Incoming bus address |
| in_dac | input | 1 | Dual-address (64-bit) cycle indicator |
| in_ext_mode | input | 1 | 1 = extended bus mode, 0 = conventional |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_claim | output | 1 | Address claimed by a window |
| out_hit_onehot | output | 4 | One-hot claiming window |
| out_hit_idx | output | 2 | Binary claiming window |
| out_iaddr | output | 36 | Translated internal address |
| out_fast_decode | output | 1 | 1 = fastest decode timing, 0 = medium |

## Verification
The bench builds the block with its default parameters: four windows and a 36-bit internal address. Four windows is enough to arrange nested and overlapping windows, so priority is exercised between neighbours at both ends of the index range. The 4-bit upper translate field lets nonzero values reach bits [35:32] of the result. Dual-address lookups are run against windows whose base high differs from zero, so the exact upper compare both passes and fails. Back-to-back strobes carry cycle stamps, so the one-clock latency is checked on every result.

// File: rtl/iat_pkg.sv
package iat_pkg;
  localparam int LOW_W = 32;
  localparam int HI_W  = 32;

  typedef enum logic [2:0] {
    FLD_BASE_LO  = 3'd0,
    FLD_BASE_HI  = 3'd1,
    FLD_LIMIT    = 3'd2,
    FLD_XLATE    = 3'd3,
    FLD_XLATE_HI = 3'd4
  } cfg_field_e;
endpackage

// File: rtl/iat_cfg_regs.sv
module iat_cfg_regs
  import iat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int UP_W    = 4,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_win,
  input  logic [2:0]                    cfg_sel,
  input  logic [LOW_W-1:0]              cfg_wdata,
  output logic [NUM_WIN-1:0][LOW_W-1:0] base_lo,
  output logic [NUM_WIN-1:0][HI_W-1:0]  base_hi,
  output logic [NUM_WIN-1:0][LOW_W-1:0] limit,
  output logic [NUM_WIN-1:0][LOW_W-1:0] xlate,
  output logic [NUM_WIN-1:0][UP_W-1:0]  xlate_hi
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel_win;
    assign sel_win = cfg_we && (cfg_win == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_lo[w]  <= '0;
        base_hi[w]  <= '0;
        limit[w]    <= '0;
        xlate[w]    <= '0;
        xlate_hi[w] <= '0;
      end else if (sel_win) begin
        case (cfg_field_e'(cfg_sel))
          FLD_BASE_LO:  base_lo[w]  <= cfg_wdata;
          FLD_BASE_HI:  base_hi[w]  <= cfg_wdata;
          FLD_LIMIT:    limit[w]    <= cfg_wdata;
          FLD_XLATE:    xlate[w]    <= cfg_wdata;
          FLD_XLATE_HI: xlate_hi[w] <= cfg_wdata[UP_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/iat_win_match.sv
module iat_win_match
  import iat_pkg::*;
#(
  parameter int UP_W = 4
) (
  input  logic [HI_W+LOW_W-1:0] addr,
  input  logic                  dac,
  input  logic [LOW_W-1:0]      base_lo,
  input  logic [HI_W-1:0]       base_hi,
  input  logic [LOW_W-1:0]      limit,
  input  logic [LOW_W-1:0]      xlate,
  input  logic [UP_W-1:0]       xlate_hi,
  output logic                  hit,
  output logic [UP_W+LOW_W-1:0] xaddr
);
  logic [LOW_W-1:0] lo;
  logic             lo_eq;
  logic             hi_eq;
  logic             enabled;

  assign lo      = addr[LOW_W-1:0];
  assign enabled = |base_lo;
  assign lo_eq   = (lo & limit) == base_lo;
  assign hi_eq   = !dac || (addr[HI_W+LOW_W-1:LOW_W] == base_hi);
  assign hit     = enabled && lo_eq && hi_eq;
  assign xaddr   = {xlate_hi, (lo & ~limit) | (xlate & limit)};
endmodule

// File: rtl/iat_prio_sel.sv
module iat_prio_sel #(
  parameter int NUM_WIN = 4,
  parameter int OUT_W   = 36,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0]            hits,
  input  logic [NUM_WIN-1:0][OUT_W-1:0] xaddrs,
  output logic                          any,
  output logic [NUM_WIN-1:0]            onehot,
  output logic [IDX_W-1:0]              idx,
  output logic [OUT_W-1:0]              addr
);
  always_comb begin
    any    = 1'b0;
    onehot = '0;
    idx    = '0;
    addr   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any       = 1'b1;
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
        addr      = xaddrs[i];
      end
    end
  end
endmodule

// File: rtl/inbound_xlate_top.sv
module inbound_xlate_top
  import iat_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int OUT_W   = 36,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_win,
  input  logic [2:0]            cfg_sel,
  input  logic [LOW_W-1:0]      cfg_wdata,
  input  logic                  in_valid,
  input  logic [HI_W+LOW_W-1:0] in_addr,
  input  logic                  in_dac,
  input  logic                  in_ext_mode,
  output logic                  out_valid,
  output logic                  out_claim,
  output logic [NUM_WIN-1:0]    out_hit_onehot,
  output logic [IDX_W-1:0]      out_hit_idx,
  output logic [OUT_W-1:0]      out_iaddr,
  output logic                  out_fast_decode
);
  localparam int UP_W = OUT_W - LOW_W;

  logic [NUM_WIN-1:0][LOW_W-1:0] base_lo;
  logic [NUM_WIN-1:0][HI_W-1:0]  base_hi;
  logic [NUM_WIN-1:0][LOW_W-1:0] limit;
  logic [NUM_WIN-1:0][LOW_W-1:0] xlate;
  logic [NUM_WIN-1:0][UP_W-1:0]  xlate_hi;
  logic [NUM_WIN-1:0]            hits;
  logic [NUM_WIN-1:0][OUT_W-1:0] xaddrs;
  logic                          sel_any;
  logic [NUM_WIN-1:0]            sel_oh;
  logic [IDX_W-1:0]              sel_idx;
  logic [OUT_W-1:0]              sel_addr;

  iat_cfg_regs #(.NUM_WIN(NUM_WIN), .UP_W(UP_W), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_win  (cfg_win),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .base_lo  (base_lo),
    .base_hi  (base_hi),
    .limit    (limit),
    .xlate    (xlate),
    .xlate_hi (xlate_hi)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    iat_win_match #(.UP_W(UP_W)) u_match (
      .addr    (in_addr),
      .dac     (in_dac),
      .base_lo (base_lo[w]),
      .base_hi (base_hi[w]),
      .limit   (limit[w]),
      .xlate   (xlate[w]),
      .xlate_hi(xlate_hi[w]),
      .hit     (hits[w]),
      .xaddr   (xaddrs[w])
    );
  end

  iat_prio_sel #(.NUM_WIN(NUM_WIN), .OUT_W(OUT_W), .IDX_W(IDX_W)) u_sel (
    .hits  (hits),
    .xaddrs(xaddrs),
    .any   (sel_any),
    .onehot(sel_oh),
    .idx   (sel_idx),
    .addr  (sel_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_claim       <= 1'b0;
      out_hit_onehot  <= '0;
      out_hit_idx     <= '0;
      out_iaddr       <= '0;
      out_fast_decode <= 1'b0;
    end else begin
      out_valid       <= in_valid;
      out_claim       <= in_valid && sel_any;
      out_hit_onehot  <= in_valid ? sel_oh   : '0;
      out_hit_idx     <= in_valid ? sel_idx  : '0;
      out_iaddr       <= in_valid ? sel_addr : '0;
      out_fast_decode <= in_valid && sel_any && in_ext_mode;
    end
  end
endmodule

// File: rtl/iat_checker.sv
module iat_checker #(
  parameter int NUM_WIN = 4,
  parameter int OUT_W   = 36,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ext_mode,
  input logic               out_valid,
  input logic               out_claim,
  input logic [NUM_WIN-1:0] out_hit_onehot,
  input logic [IDX_W-1:0]   out_hit_idx,
  input logic [OUT_W-1:0]   out_iaddr,
  input logic               out_fast_decode
);
  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_claim));
  // R6
  claim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    out_claim |-> ($countones(out_hit_onehot) == 1));
  // R6
  idx_agrees_chk: assert property (@(posedge clk) disable iff (rst)
    out_claim |-> out_hit_onehot[out_hit_idx]);
  // R10
  noclaim_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_claim |-> (out_hit_onehot == '0 && out_hit_idx == '0 && out_iaddr == '0));
  // R8
  fast_mode_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_fast_decode == (out_claim && $past(in_ext_mode))));
endmodule

bind inbound_xlate_top iat_checker #(
  .NUM_WIN(NUM_WIN), .OUT_W(OUT_W), .IDX_W(IDX_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_ext_mode    (in_ext_mode),
  .out_valid      (out_valid),
  .out_claim      (out_claim),
  .out_hit_onehot (out_hit_onehot),
  .out_hit_idx    (out_hit_idx),
  .out_iaddr      (out_iaddr),
  .out_fast_decode(out_fast_decode)
);

// File: tb/inbound_xlate_top_tb.sv
module inbound_xlate_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_win = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        in_valid = 0;
  logic [63:0] in_addr = 0;
  logic        in_dac = 0;
  logic        in_ext_mode = 0;
  logic        out_valid, out_claim, out_fast_decode;
  logic [3:0]  out_hit_onehot;
  logic [1:0]  out_hit_idx;
  logic [35:0] out_iaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  inbound_xlate_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr), .in_dac(in_dac),
    .in_ext_mode(in_ext_mode), .out_valid(out_valid), .out_claim(out_claim),
    .out_hit_onehot(out_hit_onehot), .out_hit_idx(out_hit_idx),
    .out_iaddr(out_iaddr), .out_fast_decode(out_fast_decode)
  );

  typedef struct packed {
    logic        claim;
    logic [3:0]  oh;
    logic [1:0]  idx;
    logic [35:0] iaddr;
    logic        fast;
    logic [31:0] stamp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  bit    finished = 0;

  logic [31:0] m_blo [NW];
  logic [31:0] m_bhi [NW];
  logic [31:0] m_lim [NW];
  logic [31:0] m_xl  [NW];
  logic [3:0]  m_xh  [NW];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cfg_write(input int w, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_win = 2'(w); cfg_sel = 3'(sel); cfg_wdata = d;
    case (sel)
      0: m_blo[w] = d;
      1: m_bhi[w] = d;
      2: m_lim[w] = d;
      3: m_xl[w]  = d;
      4: m_xh[w]  = d[3:0];
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  // drives one lookup on the next negedge; leaves in_valid high
  task automatic lookup(input logic [63:0] a, input logic dac, input logic ext, input string tag);
    exp_t e;
    @(negedge clk);
    e = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (m_blo[w] != 0 && (a[31:0] & m_lim[w]) == m_blo[w] &&
          (!dac || a[63:32] == m_bhi[w])) begin
        e.claim = 1; e.oh = 4'(1 << w); e.idx = 2'(w);
        e.iaddr = {m_xh[w], (a[31:0] & ~m_lim[w]) | (m_xl[w] & m_lim[w])};
        e.fast = ext;
      end
    end
    e.stamp = cyc + 1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    in_valid = 1; in_addr = a; in_dac = dac; in_ext_mode = ext;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && out_valid && !finished) begin
      if (exp_q.size() == 0) begin
        mismatched++; compared++;
        $display("FAIL R7: unexpected result act_claim=%0b exp=none", out_claim);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (out_claim !== e.claim || out_hit_onehot !== e.oh || out_hit_idx !== e.idx ||
            out_iaddr !== e.iaddr || out_fast_decode !== e.fast || cyc !== int'(e.stamp)) begin
          mismatched++;
          $display("FAIL %s: act claim=%0b oh=%b idx=%0d iaddr=%h fast=%0b cyc=%0d exp claim=%0b oh=%b idx=%0d iaddr=%h fast=%0b cyc=%0d",
                   t, out_claim, out_hit_onehot, out_hit_idx, out_iaddr, out_fast_decode, cyc,
                   e.claim, e.oh, e.idx, e.iaddr, e.fast, e.stamp);
        end
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: act=timeout exp=done");
    summary();
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_blo[w] = 0; m_bhi[w] = 0; m_lim[w] = 0; m_xl[w] = 0; m_xh[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compared++;
    if (out_valid !== 0 || out_claim !== 0 || out_hit_onehot !== 0 ||
        out_hit_idx !== 0 || out_iaddr !== 0 || out_fast_decode !== 0) begin
      mismatched++;
      $display("FAIL R9: reset outputs act valid=%0b claim=%0b iaddr=%h exp all zero",
               out_valid, out_claim, out_iaddr);
    end

    // R9: all-zero windows (limit 0 would otherwise accept anything) never claim
    lookup(64'h0000_0000_0000_0000, 0, 0, "R9");
    lookup(64'h0000_0000_1234_5678, 0, 1, "R9");
    idle();

    // R1 R2 R4 R5 window 0
    cfg_write(0, 0, 32'h1000_0000);
    cfg_write(0, 2, 32'hF000_0000);
    cfg_write(0, 3, 32'h2000_0000);
    cfg_write(0, 4, 32'h0000_0003);
    lookup(64'h0000_0000_1234_5678, 0, 0, "R2");
    idle();
    lookup(64'h0000_0000_1FFF_FFFF, 0, 1, "R8");
    idle();
    // R10 miss
    lookup(64'h0000_0000_2234_5678, 0, 1, "R10");
    idle();

    // R6 nested windows
    cfg_write(1, 0, 32'h1200_0000);
    cfg_write(1, 2, 32'hFF00_0000);
    cfg_write(1, 3, 32'h8800_0000);
    cfg_write(1, 4, 32'h0000_000A);
    cfg_write(2, 0, 32'h4000_0000);
    cfg_write(2, 2, 32'hFFFF_0000);
    cfg_write(2, 3, 32'h0005_0000);
    cfg_write(2, 4, 32'h0000_0001);
    cfg_write(3, 0, 32'h4000_0000);
    cfg_write(3, 2, 32'hF000_0000);
    cfg_write(3, 3, 32'h7000_0000);
    cfg_write(3, 4, 32'h0000_000F);
    // R7 back-to-back strobes
    lookup(64'h0000_0000_1234_5678, 0, 0, "R6");
    lookup(64'h0000_0000_4000_ABCD, 0, 1, "R4");
    lookup(64'h0000_0000_4100_0001, 0, 0, "R5");
    lookup(64'h0000_0000_1300_0000, 0, 1, "R7");
    idle();

    // R3 dual-address cycles
    cfg_write(2, 1, 32'h0000_0001);
    lookup(64'h0000_0001_4000_ABCD, 1, 1, "R3");
    idle();
    lookup(64'h0000_0002_4000_ABCD, 1, 0, "R3");
    idle();
    lookup(64'h0000_0002_4000_ABCD, 0, 0, "R3");
    idle();
    lookup(64'h0000_0000_4000_ABCD, 1, 1, "R3");
    idle();

    // R11 unused field codes
    cfg_write(0, 5, 32'hDEAD_BEEF);
    cfg_write(0, 7, 32'h0000_0000);
    cfg_write(0, 6, 32'hFFFF_FFFF);
    lookup(64'h0000_0000_1234_5678, 0, 1, "R11");
    lookup(64'h0000_0000_0234_5678, 0, 0, "R11");
    idle();

    // R9 disabling a window by clearing base low
    cfg_write(2, 0, 32'h0000_0000);
    lookup(64'h0000_0001_4000_ABCD, 0, 0, "R9");
    idle();

    repeat (4) @(negedge clk);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R7: act pending=%0d exp=0", exp_q.size());
    end
    summary();
  end
endmodule